// File: doc/BRIEF.md
# Host Mailbox Command Buffer

This block is a small shared message buffer between an external host and an embedded acquisition processor. The host sees three byte-wide registers, selected by a 2-bit register select: a buffer pointer, a data window into a 64-byte buffer, and a handshake status. To send a command the host sets the pointer to zero, streams the message through the data window (the pointer advancing after each access), then raises the request flag. A message starts with a command code byte, then a message identifier byte, then its payload; a reply uses the same two-byte header.

The processor side is a plain responder port. A one-cycle start pulse marks the request flag going high. The processor reads the message and writes its reply into the same buffer through a byte-addressed port, then strobes done, which drops the request flag. The host reads the reply by setting the pointer back to zero and reading the data window in sequence.

The request flag is guarded: a status write changes it only if that write also sets the load-enable bit. This lets the host clear a stale request before loading a new message without any risk of an accidental set.

Top module: `cmd_mailbox`

## Requirements
- R1: After reset the pointer reads 0, the status register reads 0 and the start pulse is low.
- R2: A host write with select 1 (data window) stores the byte at the current pointer, and the pointer then advances by one.
- R3: A host read with select 1 returns the byte at the current pointer and then advances it. A host write with select 0 loads the pointer from the low 6 data bits. A read with select 0 returns the pointer, zero-extended.
- R4: The pointer wraps from 63 to 0 on any data window access.
- R5: A host write with select 2 copies data bit 0 into the request flag only when data bit 1 (load-enable) is 1 in the same write. With bit 1 at 0 the flag keeps its value. Writing 0x02 clears the flag.
- R6: A read with select 2 returns the request flag in bit 0, and 0 in every other bit, including the load-enable position.
- R7: The start pulse is high for exactly the one cycle after the request flag goes from 0 to 1, and never at any other time. Re-writing 1 into a set flag gives no pulse.
- R8: A done strobe clears the request flag on the next edge. This takes priority over a host status write in the same cycle.
- R9: The processor port reads any buffer byte through a combinational read path and writes bytes that the host then reads back, so a reply overwrites the request in place.
- R10: When a processor write and a host data window write hit the same buffer byte in the same cycle, the processor byte is stored. The host pointer still advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hostSel | input | 2 | Register select: 0 pointer, 1 data window, 2 status |
| hostWr | input | 1 | Host write strobe |
| hostRd | input | 1 | Host read strobe (advances the pointer on data reads) |
| hostWdata | input | 8 | Host write data |
| hostRdata | output | 8 | Selected register value |
| apStart | output | 1 | One-cycle pulse when a request becomes pending |
| apAddr | input | 6 | Processor buffer address |
| apWe | input | 1 | Processor write enable |
| apWdata | input | 8 | Processor write data |
| apRdata | output | 8 | Buffer byte at apAddr |
| apDone | input | 1 | Processor completion strobe, clears the request flag |
| reqPending | output | 1 | Current request flag |

## Verification
The hardest cases to reach are the same-cycle collisions: a done strobe landing on the same edge as a host status write, and a processor write landing on the byte that the host pointer is writing. Neither case arises from a normal send and reply sequence. The bench drives both strobes together in one cycle on purpose, then reads the result back through the status register and the processor read port. The pointer wrap is reached by loading the pointer to 62 and writing past the end. The write at address 0 after the wrap is then confirmed by a read.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int DATA_W   = 8;
  localparam int REQ_BIT  = 0;
  localparam int LOAD_BIT = 1;

  typedef enum logic [1:0] {
    SEL_PTR  = 2'd0,
    SEL_DATA = 2'd1,
    SEL_STAT = 2'd2
  } hostSel_e;

  typedef struct packed {
    logic ptrLoad;
    logic dataWr;
    logic dataRd;
  } dpStrobe_t;
endpackage

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] hostSel,
  input  logic       hostWr,
  input  logic       hostRd,
  input  logic       reqIn,
  input  logic       loadIn,
  input  logic       apDone,
  output dpStrobe_t  strobes,
  output logic       reqPend,
  output logic       apStart
);
  logic reqPendD;
  logic statWr;

  assign statWr          = hostWr && (hostSel == SEL_STAT);
  assign strobes.ptrLoad = hostWr && (hostSel == SEL_PTR);
  assign strobes.dataWr  = hostWr && (hostSel == SEL_DATA);
  assign strobes.dataRd  = hostRd && !hostWr && (hostSel == SEL_DATA);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reqPend  <= 1'b0;
      reqPendD <= 1'b0;
    end else begin
      reqPendD <= reqPend;
      if (apDone)
        reqPend <= 1'b0;
      else if (statWr && loadIn)
        reqPend <= reqIn;
    end
  end

  assign apStart = reqPend && !reqPendD;

  // R7: pulse lasts one cycle and only while a request is pending
  p_start_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    apStart |=> !apStart);
  p_start_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
    apStart |-> reqPend);
  // R8: completion always wins
  p_done_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    apDone |=> !reqPend);
  // R5: no load-enable, no change
  p_guarded_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!apDone && !(statWr && loadIn)) |=> $stable(reqPend));
endmodule

// File: rtl/mbox_dpath.sv
module mbox_dpath
  import mbox_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpStrobe_t         strobes,
  input  logic [1:0]        hostSel,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic              reqPend,
  output logic [DATA_W-1:0] hostRdata,
  input  logic [AW-1:0]     apAddr,
  input  logic              apWe,
  input  logic [DATA_W-1:0] apWdata,
  output logic [DATA_W-1:0] apRdata
);
  logic [AW-1:0]     ptr;
  logic [DATA_W-1:0] mem [DEPTH];
  logic              clash;

  assign clash = apWe && (apAddr == ptr);

  always_ff @(posedge clk) begin
    if (!rst_n)
      ptr <= '0;
    else if (strobes.ptrLoad)
      ptr <= hostWdata[AW-1:0];
    else if (strobes.dataWr || strobes.dataRd)
      ptr <= ptr + AW'(1);
  end

  always_ff @(posedge clk) begin
    if (strobes.dataWr && !clash)
      mem[ptr] <= hostWdata;
    if (apWe)
      mem[apAddr] <= apWdata;
  end

  always_comb begin
    unique case (hostSel)
      SEL_PTR:  hostRdata = {{(DATA_W-AW){1'b0}}, ptr};
      SEL_DATA: hostRdata = mem[ptr];
      SEL_STAT: hostRdata = DATA_W'(reqPend) << REQ_BIT;
      default:  hostRdata = '0;
    endcase
  end

  assign apRdata = mem[apAddr];

  // R2/R4: data access steps the pointer modulo depth
  p_ptr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.dataWr || strobes.dataRd) |=> ptr == $past(ptr) + AW'(1));
  // R3: pointer load
  p_ptr_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.ptrLoad |=> ptr == $past(hostWdata[AW-1:0]));
  // R2: host byte lands at old pointer
  p_host_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.dataWr && !clash) |=> mem[$past(ptr)] == $past(hostWdata));
  // R10: processor byte wins
  p_ap_store_r10: assert property (@(posedge clk) disable iff (!rst_n)
    apWe |=> mem[$past(apAddr)] == $past(apWdata));
endmodule

// File: rtl/cmd_mailbox.sv
module cmd_mailbox
  import mbox_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        hostSel,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  output logic              apStart,
  input  logic [AW-1:0]     apAddr,
  input  logic              apWe,
  input  logic [DATA_W-1:0] apWdata,
  output logic [DATA_W-1:0] apRdata,
  input  logic              apDone,
  output logic              reqPending
);
  dpStrobe_t strobes;

  mbox_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .hostSel(hostSel), .hostWr(hostWr), .hostRd(hostRd),
    .reqIn(hostWdata[REQ_BIT]), .loadIn(hostWdata[LOAD_BIT]), .apDone(apDone),
    .strobes(strobes), .reqPend(reqPending), .apStart(apStart)
  );

  mbox_dpath #(.DEPTH(DEPTH)) u_dpath (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .hostSel(hostSel),
    .hostWdata(hostWdata), .reqPend(reqPending), .hostRdata(hostRdata),
    .apAddr(apAddr), .apWe(apWe), .apWdata(apWdata), .apRdata(apRdata)
  );
endmodule

// File: tb/tb_cmd_mailbox.sv
module tb_cmd_mailbox;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] hostSel = 2'd0;
  logic       hostWr = 1'b0, hostRd = 1'b0;
  logic [7:0] hostWdata = 8'h00;
  logic [7:0] hostRdata;
  logic       apStart;
  logic [5:0] apAddr = 6'd0;
  logic       apWe = 1'b0;
  logic [7:0] apWdata = 8'h00;
  logic [7:0] apRdata;
  logic       apDone = 1'b0;
  logic       reqPending;

  int tests = 0, fails = 0;
  logic [7:0] expQ[$];
  string      tagQ[$];

  always #2.5 clk = ~clk;

  cmd_mailbox dut (.*);

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // monitor: compares every host read against the scoreboard
  always @(negedge clk) begin
    if (hostRd && expQ.size() > 0) begin
      automatic logic [7:0] e = expQ.pop_front();
      automatic string t = tagQ.pop_front();
      check(t, hostRdata, e);
    end
  end

  task automatic hostWrite(input logic [1:0] sel, input logic [7:0] d);
    hostSel = sel; hostWdata = d; hostWr = 1'b1;
    @(posedge clk); #1;
    hostWr = 1'b0;
  endtask

  task automatic hostRead(input logic [1:0] sel, input logic [7:0] exp, input string tag);
    expQ.push_back(exp); tagQ.push_back(tag);
    hostSel = sel; hostRd = 1'b1;
    @(posedge clk); #1;
    hostRd = 1'b0;
  endtask

  task automatic apWrite(input logic [5:0] a, input logic [7:0] d);
    apAddr = a; apWdata = d; apWe = 1'b1;
    @(posedge clk); #1;
    apWe = 1'b0;
  endtask

  task automatic apReadChk(input logic [5:0] a, input logic [7:0] exp, input string tag);
    apAddr = a;
    @(negedge clk);
    check(tag, apRdata, exp);
    @(posedge clk); #1;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    rst_n = 1'b1;
    // R1
    check("R1 start", {7'd0, apStart}, 8'h00);
    hostRead(2'd0, 8'h00, "R1 ptr");
    hostRead(2'd2, 8'h00, "R1 status");
    // R2
    hostWrite(2'd0, 8'h00);
    hostWrite(2'd1, 8'hA5); hostWrite(2'd1, 8'h11);
    hostWrite(2'd1, 8'h22); hostWrite(2'd1, 8'h33);
    hostRead(2'd0, 8'h04, "R2 ptr advance");
    // R3
    hostWrite(2'd0, 8'h00);
    hostRead(2'd1, 8'hA5, "R3 byte0"); hostRead(2'd1, 8'h11, "R3 byte1");
    hostRead(2'd1, 8'h22, "R3 byte2"); hostRead(2'd1, 8'h33, "R3 byte3");
    hostRead(2'd0, 8'h04, "R3 ptr after reads");
    // R4
    hostWrite(2'd0, 8'd62);
    hostWrite(2'd1, 8'h70); hostWrite(2'd1, 8'h71); hostWrite(2'd1, 8'h72);
    hostRead(2'd0, 8'h01, "R4 wrapped ptr");
    hostWrite(2'd0, 8'h00);
    hostRead(2'd1, 8'h72, "R4 byte at 0");
    // R5: no load-enable
    hostWrite(2'd2, 8'h01);
    check("R5 no load", {7'd0, reqPending}, 8'h00);
    check("R7 no pulse", {7'd0, apStart}, 8'h00);
    // R5/R7: set with load-enable
    hostWrite(2'd2, 8'h03);
    @(negedge clk); check("R7 pulse", {7'd0, apStart}, 8'h01);
    @(posedge clk); #1;
    check("R7 pulse ends", {7'd0, apStart}, 8'h00);
    hostRead(2'd2, 8'h01, "R6 status read");
    hostWrite(2'd2, 8'h03);
    check("R7 no repeat", {7'd0, apStart}, 8'h00);
    // R9
    apReadChk(6'd0, 8'h72, "R9 ap read0");
    apReadChk(6'd1, 8'h11, "R9 ap read1");
    apWrite(6'd0, 8'hC0); apWrite(6'd1, 8'hC1); apWrite(6'd2, 8'hC2);
    hostWrite(2'd0, 8'h00);
    hostRead(2'd1, 8'hC0, "R9 reply0"); hostRead(2'd1, 8'hC1, "R9 reply1");
    hostRead(2'd1, 8'hC2, "R9 reply2");
    // R8
    apDone = 1'b1; @(posedge clk); #1; apDone = 1'b0;
    hostRead(2'd2, 8'h00, "R8 done clears");
    hostWrite(2'd2, 8'h03);
    apDone = 1'b1; hostSel = 2'd2; hostWdata = 8'h03; hostWr = 1'b1;
    @(posedge clk); #1; apDone = 1'b0; hostWr = 1'b0;
    hostRead(2'd2, 8'h00, "R8 priority");
    // R5: stale clear
    hostWrite(2'd2, 8'h03);
    check("R5 set", {7'd0, reqPending}, 8'h01);
    hostWrite(2'd2, 8'h02);
    hostRead(2'd2, 8'h00, "R5 clear");
    // R10
    hostWrite(2'd0, 8'd5);
    hostSel = 2'd1; hostWdata = 8'h55; hostWr = 1'b1;
    apAddr = 6'd5; apWdata = 8'h99; apWe = 1'b1;
    @(posedge clk); #1; hostWr = 1'b0; apWe = 1'b0;
    apReadChk(6'd5, 8'h99, "R10 ap wins");
    hostRead(2'd0, 8'h06, "R10 ptr advanced");
    repeat (2) @(posedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule